// File: doc/BRIEF.md
# CPU Interface Acknowledge Logic

This block sits between an interrupt distributor and one processor. The distributor supplies, for every candidate line, a pending flag and an 8-bit priority value. The block chooses the most urgent pending line, compares it against a software-programmed priority threshold, and drives a single interrupt-request line to the processor. A lower priority value means more urgency. When two lines tie, the lower line index wins. The interrupt ID of a line equals its index.

The processor talks to the block through a small register port with four word offsets. Offset 0 is the control register, and its bit 0 enables signalling. Offset 1 is the priority threshold, held in bits 7:0. Offset 2 is the acknowledge register. Reading it returns the ID of the winning line and marks that line active. Offset 3 is the completion register. Writing the active ID there ends the interrupt. When no line qualifies, the acknowledge read returns the reserved ID 1023 and leaves all state alone. Only one interrupt can be active at a time.

The control core is a two-state machine. In state IDLE no interrupt is active. In state ACTIVE one interrupt has been acknowledged and its ID and priority are held. The transition TAKE (IDLE to ACTIVE) fires on an acknowledge read that finds a qualifying winner. The transition COMPLETE (ACTIVE to IDLE) fires on a completion write whose ID matches the held ID. Every other event keeps the current state.

Top module: `cpu_irq_ack_if`

## Requirements
- R1: After reset the enable bit is 0, the threshold is 0xF0, the state is IDLE and the request line is low.
- R2: Offset 0 reads back the enable in bit 0, and offset 1 reads back the threshold in bits 7:0, with all other bits zero. Read data appears on the cycle after the read strobe and is held until the next read.
- R3: The winner is the pending line with the smallest priority value. On a tie the lower index wins, and the returned ID is the line index.
- R4: A winner is signalled only if its priority value is strictly below the threshold.
- R5: An acknowledge read (offset 2) with a qualifying winner in IDLE returns that ID in bits 9:0, with bits 31:10 zero, and enters ACTIVE.
- R6: An acknowledge read returns 1023 and changes no state when nothing qualifies.
- R7: In ACTIVE the request line is raised only for a winner strictly more urgent than the active priority. An acknowledge read in ACTIVE returns 1023 and keeps the active interrupt.
- R8: A write to offset 3 whose bits 9:0 equal the active ID returns the block to IDLE. Any other ID value is ignored.
- R9: With the enable bit at 0 the request line stays low and acknowledge reads return 1023.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Word offset: 0 control, 1 threshold, 2 acknowledge, 3 completion |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| line_pend | input | N_LINES | Pending flag per line |
| line_prio | input | 8*N_LINES | Priority per line, line i in bits 8i+7:8i |
| cpu_irq | output | 1 | Interrupt request to the processor |

## Verification
The main function is driven with random pending sets and priorities drawn from a coarse grid, so that ties between lines are frequent. It runs under several threshold values. Each pattern is acknowledged, then completed first with a wrong ID and then with the right one. This separates winner choice, tie order, threshold filtering and active blocking.

Directed patterns cover further cases:
- a priority equal to the threshold, against one step below it;
- a full tie across all lines;
- a more urgent line arriving while another is active;
- disabled operation, followed by a later acknowledge that shows no state was changed.

// File: rtl/cpuif_pkg.sv
package cpuif_pkg;
    localparam int ID_W        = 10;
    localparam int PRIO_W      = 8;
    localparam logic [ID_W-1:0] SPURIOUS_ID = 10'd1023;
    localparam logic [PRIO_W-1:0] MASK_RESET = 8'hF0;

    localparam logic [1:0] OFS_CTRL = 2'd0;
    localparam logic [1:0] OFS_MASK = 2'd1;
    localparam logic [1:0] OFS_ACK  = 2'd2;
    localparam logic [1:0] OFS_EOI  = 2'd3;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_ACTIVE = 1'b1
    } ack_state_t;
endpackage

// File: rtl/cpuif_prio_select.sv
module cpuif_prio_select
    import cpuif_pkg::*;
#(
    parameter int N_LINES = 8
) (
    input  logic [N_LINES-1:0]        pend_i,
    input  logic [N_LINES*PRIO_W-1:0] prio_i,
    output logic                      found_o,
    output logic [ID_W-1:0]           win_id_o,
    output logic [PRIO_W-1:0]         win_prio_o
);
    always_comb begin
        found_o    = 1'b0;
        win_id_o   = '0;
        win_prio_o = '1;
        for (int i = 0; i < N_LINES; i++) begin
            if (pend_i[i] && (!found_o || prio_i[i*PRIO_W +: PRIO_W] < win_prio_o)) begin
                found_o    = 1'b1;
                win_id_o   = ID_W'(i);
                win_prio_o = prio_i[i*PRIO_W +: PRIO_W];
            end
        end
    end
endmodule

// File: rtl/cpuif_ctrl_regs.sv
module cpuif_ctrl_regs
    import cpuif_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctrl_i,
    input  logic              wr_mask_i,
    input  logic [31:0]       wdata_i,
    output logic              enable_o,
    output logic [PRIO_W-1:0] mask_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            enable_o <= 1'b0;
            mask_o   <= MASK_RESET;
        end else begin
            if (wr_ctrl_i) enable_o <= wdata_i[0];
            if (wr_mask_i) mask_o   <= wdata_i[PRIO_W-1:0];
        end
    end
endmodule

// File: rtl/cpu_irq_ack_if.sv
module cpu_irq_ack_if
    import cpuif_pkg::*;
#(
    parameter int N_LINES = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bus_sel,
    input  logic                      bus_wr,
    input  logic [1:0]                bus_addr,
    input  logic [31:0]               bus_wdata,
    output logic [31:0]               bus_rdata,
    input  logic [N_LINES-1:0]        line_pend,
    input  logic [N_LINES*PRIO_W-1:0] line_prio,
    output logic                      cpu_irq
);
    localparam int MAX_LINES = 1020;

    initial begin
        if (N_LINES < 1 || N_LINES > MAX_LINES)
            $error("N_LINES out of range");
    end

    ack_state_t        state_q, state_d;
    logic [ID_W-1:0]   act_id_q;
    logic [PRIO_W-1:0] act_prio_q;
    logic              enable;
    logic [PRIO_W-1:0] mask;
    logic              found;
    logic [ID_W-1:0]   win_id;
    logic [PRIO_W-1:0] win_prio;
    logic              qualify;
    logic              ack_rd, eoi_wr, take, complete;

    cpuif_prio_select #(.N_LINES(N_LINES)) sel_i (
        .pend_i    (line_pend),
        .prio_i    (line_prio),
        .found_o   (found),
        .win_id_o  (win_id),
        .win_prio_o(win_prio)
    );

    cpuif_ctrl_regs regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_ctrl_i(bus_sel && bus_wr && bus_addr == OFS_CTRL),
        .wr_mask_i(bus_sel && bus_wr && bus_addr == OFS_MASK),
        .wdata_i  (bus_wdata),
        .enable_o (enable),
        .mask_o   (mask)
    );

    assign ack_rd = bus_sel && !bus_wr && bus_addr == OFS_ACK;
    assign eoi_wr = bus_sel &&  bus_wr && bus_addr == OFS_EOI;

    // Output process: qualification and request line
    always_comb begin
        qualify = 1'b0;
        unique case (state_q)
            ST_IDLE:   qualify = enable && found && (win_prio < mask);
            ST_ACTIVE: qualify = enable && found && (win_prio < mask) && (win_prio < act_prio_q);
        endcase
        cpu_irq  = qualify;
        take     = 1'b0;
        complete = 1'b0;
        unique case (state_q)
            ST_IDLE:   take     = ack_rd && qualify;
            ST_ACTIVE: complete = eoi_wr && (bus_wdata[ID_W-1:0] == act_id_q);
        endcase
    end

    // Next-state logic: TAKE and COMPLETE transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (take)     state_d = ST_ACTIVE;
            ST_ACTIVE: if (complete) state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Active record
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_id_q   <= '0;
            act_prio_q <= '1;
        end else if (take) begin
            act_id_q   <= win_id;
            act_prio_q <= win_prio;
        end
    end

    // Registered read data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_sel && !bus_wr) begin
            unique case (bus_addr)
                OFS_CTRL: bus_rdata <= {31'b0, enable};
                OFS_MASK: bus_rdata <= {{(32-PRIO_W){1'b0}}, mask};
                OFS_ACK:  bus_rdata <= {{(32-ID_W){1'b0}}, take ? win_id : SPURIOUS_ID};
                OFS_EOI:  bus_rdata <= '0;
            endcase
        end
    end
endmodule

// File: rtl/cpuif_ack_chk.sv
module cpuif_ack_chk
    import cpuif_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [1:0]        bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic              cpu_irq,
    input logic              enable,
    input logic [PRIO_W-1:0] mask,
    input logic [PRIO_W-1:0] win_prio,
    input ack_state_t        state_q,
    input logic [ID_W-1:0]   act_id_q
);
    // R9
    irq_off_when_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> !cpu_irq);

    // R4
    irq_below_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_irq |-> (win_prio < mask));

    // R7
    ack_in_active_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_addr == OFS_ACK && state_q == ST_ACTIVE)
        |=> (bus_rdata[ID_W-1:0] == SPURIOUS_ID && state_q == ST_ACTIVE));

    // R5
    ack_take_activates_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_addr == OFS_ACK && state_q == ST_IDLE)
        |=> (bus_rdata[ID_W-1:0] == SPURIOUS_ID || state_q == ST_ACTIVE));

    // R8
    eoi_mismatch_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == OFS_EOI && state_q == ST_ACTIVE
         && bus_wdata[ID_W-1:0] != act_id_q)
        |=> (state_q == ST_ACTIVE && $stable(act_id_q)));
endmodule

bind cpu_irq_ack_if cpuif_ack_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_sel  (bus_sel),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .cpu_irq  (cpu_irq),
    .enable   (enable),
    .mask     (mask),
    .win_prio (win_prio),
    .state_q  (state_q),
    .act_id_q (act_id_q)
);

// File: tb/cpu_irq_ack_if_tb_top.sv
`timescale 1ns/1ps
module cpu_irq_ack_if_tb_top;
    localparam int N = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_sel = 1'b0, bus_wr = 1'b0;
    logic [1:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [N-1:0]  line_pend = '0;
    logic [N*8-1:0] line_prio = '0;
    logic          cpu_irq;

    int checks = 0, fails = 0;
    bit done = 0;

    // bench model
    bit       m_en = 0;
    int       m_mask = 'hF0;
    bit       m_act = 0;
    int       m_act_id = 0, m_act_prio = 255;

    always #2.5 clk = ~clk;

    cpu_irq_ack_if #(.N_LINES(N)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .line_pend(line_pend), .line_prio(line_prio), .cpu_irq(cpu_irq)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic bus_write(logic [1:0] a, logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic bus_read(logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        @(negedge clk);
        bus_sel = 0;
        #1 d = bus_rdata;
    endtask

    function automatic void winner(output bit f, output int id, output int p);
        f = 0; id = 0; p = 255;
        for (int i = 0; i < N; i++)
            if (line_pend[i] && (!f || int'(line_prio[i*8 +: 8]) < p)) begin
                f = 1; id = i; p = line_prio[i*8 +: 8];
            end
    endfunction

    function automatic bit exp_irq();
        bit f; int id, p;
        winner(f, id, p);
        return m_en && f && p < m_mask && (!m_act || p < m_act_prio);
    endfunction

    // acknowledge with model update; returns whether an interrupt was taken
    task automatic ack_and_check(string req, output bit took);
        bit f; int id, p; logic [31:0] rd;
        winner(f, id, p);
        took = m_en && f && p < m_mask && !m_act;
        bus_read(2'd2, rd);
        check(req, rd, took ? id : 1023);
        if (took) begin m_act = 1; m_act_id = id; m_act_prio = p; end
    endtask

    task automatic settle_irq(string req);
        #1 check(req, cpu_irq, exp_irq());
    endtask

    initial begin
        logic [31:0] rd;
        bit took;
        int masks[4] = '{'hF0, 'h80, 'h41, 'h01};
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check("R1 irq", cpu_irq, 0);
        bus_read(2'd0, rd); check("R1 enable", rd, 0);
        bus_read(2'd1, rd); check("R1 mask", rd, 'hF0);
        // R9 disabled: pending line, no irq, spurious ack
        line_pend = 8'h01; line_prio = '0;
        settle_irq("R9 irq disabled");
        ack_and_check("R9 ack disabled", took);
        // R2 readback
        bus_write(2'd0, 32'hFFFF_FFFF); m_en = 1;
        bus_read(2'd0, rd); check("R2 ctrl", rd, 1);
        bus_write(2'd1, 32'h1234_5680); m_mask = 'h80;
        bus_read(2'd1, rd); check("R2 mask", rd, 'h80);
        // R6 nothing pending / state unchanged (R9 ack left idle)
        line_pend = '0;
        settle_irq("R6 irq none");
        ack_and_check("R6 ack none", took);
        // R4 equal to mask blocked, one below passes
        line_pend = 8'h10; line_prio = '0; line_prio[4*8 +: 8] = 8'h80;
        settle_irq("R4 equal mask");
        ack_and_check("R4 ack equal mask", took);
        line_prio[4*8 +: 8] = 8'h7F;
        settle_irq("R4 below mask");
        ack_and_check("R5 ack take", took);
        // R7 active: equal not signalled, more urgent signalled, ack spurious
        line_pend = 8'h30; line_prio[5*8 +: 8] = 8'h7F;
        settle_irq("R7 equal blocked");
        check("R7 irq low", cpu_irq, 0);
        line_prio[5*8 +: 8] = 8'h10;
        settle_irq("R7 urgent");
        check("R7 irq high", cpu_irq, 1);
        ack_and_check("R7 ack active", took);
        // R8 wrong id ignored, right id completes
        bus_write(2'd3, 32'd5);
        settle_irq("R8 wrong eoi");
        bus_write(2'd3, 32'h0000_FC04); m_act = 0;
        settle_irq("R8 right eoi");
        ack_and_check("R8 ack after eoi", took);
        bus_write(2'd3, 32'd5); m_act = 0;
        // R3 full tie
        line_pend = '1;
        for (int i = 0; i < N; i++) line_prio[i*8 +: 8] = 8'h20;
        ack_and_check("R3 full tie", took);
        bus_write(2'd3, 32'd0); m_act = 0;
        // R9 disable after pending: no state change
        bus_write(2'd0, 0); m_en = 0;
        settle_irq("R9 irq off");
        ack_and_check("R9 ack off", took);
        bus_write(2'd0, 1); m_en = 1;
        ack_and_check("R9 ack after re-enable", took);
        bus_write(2'd3, 32'd0); m_act = 0;
        // sweep R3 R4 R5 R7 R8 across masks
        foreach (masks[k]) begin
            bus_write(2'd1, masks[k]); m_mask = masks[k];
            for (int t = 0; t < 150; t++) begin
                @(negedge clk);
                line_pend = N'($urandom);
                for (int i = 0; i < N; i++)
                    line_prio[i*8 +: 8] = 8'($urandom_range(0, 7) * 32 + (t % 2));
                settle_irq("R3 R4 sweep irq");
                ack_and_check("R3 R5 sweep ack", took);
                settle_irq("R7 sweep active irq");
                if (took) begin
                    bus_write(2'd3, (m_act_id + 1) % N);
                    settle_irq("R8 sweep wrong eoi");
                    ack_and_check("R7 sweep ack active", took);
                    bus_write(2'd3, m_act_id); m_act = 0;
                    settle_irq("R8 sweep eoi");
                end
            end
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule